// File: doc/BRIEF.md
# Eight-Bit Arithmetic Logic Unit with Flag Byte

This block performs the byte-wide arithmetic and logic of a small processor core and produces the full eight-bit status byte that goes with each operation. A mode input picks among the accumulator operation group, increment, decrement, negate, complement, carry set and carry invert, plus an idle code. Within the group, a three-bit operation select picks add, add-with-carry, subtract, subtract-with-borrow, AND, XOR, OR or compare.

The caller supplies the accumulator, a second operand and the current flag byte. The flag byte is needed because some operations use the incoming carry and several keep flag bits unchanged. The block returns the result, the new flag byte and a result write-enable. All three outputs are registered, so they appear on the clock edge after the inputs are presented. A synchronous active-high reset clears them.

The two undocumented flag bits, 5 and 3, are generated as well. They normally mirror the result. Compare takes them from the operand. The carry operations take them from the accumulator.

Top module: `alu8_core`

## Requirements
- R1: Flag byte layout is S=bit7, Z=bit6, X5=bit5, H=bit4, X3=bit3, PV=bit2, N=bit1, C=bit0. In mode 0, op 000 adds and op 001 adds plus incoming C. Op 010 subtracts and op 011 subtracts the operand and incoming C. The result is written. S, Z and C come from the operation, with C meaning carry for add and borrow for subtract. H is the carry or borrow out of bit 3. PV is two's-complement overflow. N is 0 for add and 1 for subtract.
- R2: Outputs register on the rising clock edge after the inputs. While reset is high at an edge, the result, flag byte and write-enable all become 0.
- R3: Mode 0 logic operations are op 100 AND, op 101 XOR and op 110 OR. Each writes the result and sets PV to 1 when the result has an even number of ones. N and C become 0. H becomes 1 for AND and 0 for XOR and OR.
- R4: Mode 0, op 111 (compare) sets S, Z, H, PV, N=1 and C as for accumulator minus operand. X5 and X3 are copied from the operand. The write-enable is 0 and the result port shows the accumulator unchanged.
- R5: Mode 1 (increment) and mode 2 (decrement) act on the operand, not the accumulator, and write the result. S, Z, H and PV are set as for adding or subtracting 1, and N is 0 for increment and 1 for decrement. C keeps its incoming value.
- R6: Mode 4 (complement) writes the bitwise inverse of the accumulator and sets H=1 and N=1. X5 and X3 come from the new value. S, Z, PV and C keep their incoming values.
- R7: Mode 3 (negate) writes 0 minus the accumulator, with all flags set as for that subtraction.
- R8: Mode 5 sets C=1, H=0 and N=0. Mode 6 inverts C, copies the old C into H and clears N. In both modes X5 and X3 are copied from the accumulator, S, Z and PV keep their incoming values, the write-enable is 0 and the result port shows the accumulator.
- R9: In every mode other than compare, carry set, carry invert and idle, X5 and X3 equal bits 5 and 3 of the written result.
- R10: Mode 7 (idle) passes the incoming flag byte through unchanged, shows the accumulator on the result port and keeps the write-enable at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Operation family: 0 group, 1 increment, 2 decrement, 3 negate, 4 complement, 5 carry set, 6 carry invert, 7 idle |
| op | input | 3 | Group operation select, used in mode 0 |
| acc | input | DW | Accumulator value |
| opnd | input | DW | Second operand; also the target of increment and decrement |
| flags_in | input | 8 | Current flag byte |
| res_out | output | DW | Registered result |
| flags_out | output | 8 | Registered new flag byte |
| res_we | output | 1 | Registered result write-enable |

## Verification
Add-with-carry is swept over every operand pair and both incoming carry values. A wrong carry-in path or a misplaced half-carry tap would show up there as a bad sum or a bad H bit on nibble-crossing values. Subtraction, borrow and negate are strided across the operand space to reach the borrow, overflow and zero-result edges: 0x80 minus 1, negating 0x80, and negating 0. A wrong inversion of carry into borrow would flip C on every one of these.

Compare is checked for taking X5 and X3 from the operand and for leaving the write-enable low. A design that copied those bits from the difference, or that wrote the result, would fail here. Increment and decrement are run with both incoming carry values to catch a design that overwrites C. The carry operations, complement and idle are run with varied incoming flag bytes to catch bits that should have been preserved.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [2:0] {
    MD_GRP  = 3'd0,
    MD_INC  = 3'd1,
    MD_DEC  = 3'd2,
    MD_NEG  = 3'd3,
    MD_CPL  = 3'd4,
    MD_SCF  = 3'd5,
    MD_CCF  = 3'd6,
    MD_IDLE = 3'd7
  } alu_mode_e;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_AND = 3'd4,
    OP_XOR = 3'd5,
    OP_OR  = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  localparam int FW   = 8;
  localparam int FB_S = 7;
  localparam int FB_Z = 6;
  localparam int FB_5 = 5;
  localparam int FB_H = 4;
  localparam int FB_3 = 3;
  localparam int FB_P = 2;
  localparam int FB_N = 1;
  localparam int FB_C = 0;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          cout,
  output logic          hout,
  output logic          vout
);
  localparam int HB = DW / 2;

  logic [DW-1:0] bx;
  logic          cx;
  logic [DW:0]   full;
  logic [HB:0]   half;

  always_comb begin
    bx   = sub ? ~b : b;
    cx   = sub ? ~cin : cin;
    full = {1'b0, a} + {1'b0, bx} + {{DW{1'b0}}, cx};
    half = {1'b0, a[HB-1:0]} + {1'b0, bx[HB-1:0]} + {{HB{1'b0}}, cx};
    sum  = full[DW-1:0];
    cout = full[DW] ^ sub;
    hout = half[HB] ^ sub;
    vout = (a[DW-1] == bx[DW-1]) && (sum[DW-1] != a[DW-1]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [1:0]    sel,
  output logic [DW-1:0] y
);
  always_comb begin
    case (sel)
      2'd0:    y = a & b;
      2'd1:    y = a ^ b;
      default: y = a | b;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    mode,
  input  logic [2:0]    op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  input  logic [FW-1:0] flags_in,
  output logic [DW-1:0] res_out,
  output logic [FW-1:0] flags_out,
  output logic          res_we
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] as_a, as_b, as_sum, lg_y;
  logic          as_sub, as_cin, as_c, as_h, as_v;
  logic [DW-1:0] nxt_res;
  logic [FW-1:0] nxt_flg;
  logic          nxt_we;
  logic          old_c;

  assign old_c = flags_in[FB_C];

  always_comb begin
    as_a   = acc;
    as_b   = opnd;
    as_sub = 1'b0;
    as_cin = 1'b0;
    case (mode)
      MD_GRP: begin
        as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
        as_cin = ((op == OP_ADC) || (op == OP_SBC)) ? old_c : 1'b0;
      end
      MD_INC: begin
        as_a = opnd;
        as_b = ONE;
      end
      MD_DEC: begin
        as_a   = opnd;
        as_b   = ONE;
        as_sub = 1'b1;
      end
      MD_NEG: begin
        as_a   = '0;
        as_b   = acc;
        as_sub = 1'b1;
      end
      default: ;
    endcase
  end

  alu8_addsub #(.DW(DW)) u_addsub (
    .a(as_a), .b(as_b), .sub(as_sub), .cin(as_cin),
    .sum(as_sum), .cout(as_c), .hout(as_h), .vout(as_v)
  );

  alu8_logic #(.DW(DW)) u_logic (
    .a(acc), .b(opnd), .sel(op[1:0] ^ 2'b00), .y(lg_y)
  );

  always_comb begin
    nxt_res = acc;
    nxt_flg = flags_in;
    nxt_we  = 1'b0;
    case (mode)
      MD_GRP: begin
        if (op[2] && (op != OP_CMP)) begin
          nxt_res = lg_y;
          nxt_we  = 1'b1;
          nxt_flg = {lg_y[DW-1], ~|lg_y, lg_y[5], (op == OP_AND), lg_y[3],
                     ~^lg_y, 1'b0, 1'b0};
        end else if (op == OP_CMP) begin
          nxt_flg = {as_sum[DW-1], ~|as_sum, opnd[5], as_h, opnd[3],
                     as_v, 1'b1, as_c};
        end else begin
          nxt_res = as_sum;
          nxt_we  = 1'b1;
          nxt_flg = {as_sum[DW-1], ~|as_sum, as_sum[5], as_h, as_sum[3],
                     as_v, as_sub, as_c};
        end
      end
      MD_INC, MD_DEC: begin
        nxt_res = as_sum;
        nxt_we  = 1'b1;
        nxt_flg = {as_sum[DW-1], ~|as_sum, as_sum[5], as_h, as_sum[3],
                   as_v, as_sub, old_c};
      end
      MD_NEG: begin
        nxt_res = as_sum;
        nxt_we  = 1'b1;
        nxt_flg = {as_sum[DW-1], ~|as_sum, as_sum[5], as_h, as_sum[3],
                   as_v, 1'b1, as_c};
      end
      MD_CPL: begin
        nxt_res = ~acc;
        nxt_we  = 1'b1;
        nxt_flg = {flags_in[FB_S], flags_in[FB_Z], ~acc[5], 1'b1, ~acc[3],
                   flags_in[FB_P], 1'b1, old_c};
      end
      MD_SCF: begin
        nxt_flg = {flags_in[FB_S], flags_in[FB_Z], acc[5], 1'b0, acc[3],
                   flags_in[FB_P], 1'b0, 1'b1};
      end
      MD_CCF: begin
        nxt_flg = {flags_in[FB_S], flags_in[FB_Z], acc[5], old_c, acc[3],
                   flags_in[FB_P], 1'b0, ~old_c};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out   <= '0;
      flags_out <= '0;
      res_we    <= 1'b0;
    end else begin
      res_out   <= nxt_res;
      flags_out <= nxt_flg;
      res_we    <= nxt_we;
    end
  end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    mode,
  input logic [2:0]    op,
  input logic [DW-1:0] acc,
  input logic [DW-1:0] opnd,
  input logic [FW-1:0] flags_in,
  input logic [DW-1:0] res_out,
  input logic [FW-1:0] flags_out,
  input logic          res_we
);
  AST_LOGIC_NC: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == MD_GRP && $past(op[2]) && $past(op) != OP_CMP)
    |-> (flags_out[FB_N] == 1'b0 && flags_out[FB_C] == 1'b0 && res_we)); // R3

  AST_CMP_NOWRITE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == MD_GRP && $past(op) == OP_CMP)
    |-> (!res_we && flags_out[FB_5] == $past(opnd[5]) && flags_out[FB_3] == $past(opnd[3])
         && flags_out[FB_N])); // R4

  AST_INCDEC_KEEPC: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mode) == MD_INC || $past(mode) == MD_DEC))
    |-> (flags_out[FB_C] == $past(flags_in[FB_C]))); // R5

  AST_CPL_VALUE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == MD_CPL)
    |-> (res_out == ~$past(acc) && flags_out[FB_H] && flags_out[FB_N])); // R6

  AST_SCF_BITS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == MD_SCF)
    |-> (flags_out[FB_C] && !flags_out[FB_H] && !flags_out[FB_N] && !res_we)); // R8

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == MD_IDLE)
    |-> (flags_out == $past(flags_in) && !res_we)); // R10
endmodule

bind alu8_core alu8_core_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .op(op), .acc(acc), .opnd(opnd),
  .flags_in(flags_in), .res_out(res_out), .flags_out(flags_out), .res_we(res_we)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode = 3'd0;
  logic [2:0] op = 3'd0;
  logic [7:0] acc = 8'd0;
  logic [7:0] opnd = 8'd0;
  logic [7:0] flags_in = 8'd0;
  logic [7:0] res_out, flags_out;
  logic       res_we;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  alu8_core dut (
    .clk(clk), .rst(rst), .mode(mode), .op(op), .acc(acc), .opnd(opnd),
    .flags_in(flags_in), .res_out(res_out), .flags_out(flags_out), .res_we(res_we)
  );

  function automatic int sgn(input logic [7:0] v);
    return (v > 8'd127) ? int'(v) - 256 : int'(v);
  endfunction

  function automatic logic [16:0] model(input logic [2:0] m, input logic [2:0] o,
      input logic [7:0] a, input logic [7:0] b, input logic [7:0] f);
    int r, h, s; logic [7:0] y; logic [7:0] nf; logic we; int ci; bit issub;
    logic [7:0] x; logic [7:0] srcx;
    y = a; nf = f; we = 0;
    ci = (m == 3'd0 && (o == 3'd1 || o == 3'd3)) ? int'(f[0]) : 0;
    x = b; issub = 0;
    if (m == 3'd1 || m == 3'd2) begin x = 8'd1; end
    if (m == 3'd2 || (m == 3'd0 && (o == 3'd2 || o == 3'd3 || o == 3'd7))) issub = 1;
    if (m <= 3'd2 || m == 3'd3) begin
      int lhs;
      lhs = (m == 3'd1 || m == 3'd2) ? int'(b) : ((m == 3'd3) ? 0 : int'(a));
      if (m == 3'd3) begin x = a; issub = 1; end
      if (issub) begin
        r = lhs - int'(x) - ci;
        h = (lhs % 16) - int'(x[3:0]) - ci;
        s = sgn(8'(lhs)) - sgn(x) - ci;
      end else begin
        r = lhs + int'(x) + ci;
        h = (lhs % 16) + int'(x[3:0]) + ci;
        s = sgn(8'(lhs)) + sgn(x) + ci;
      end
      y = 8'(r);
      srcx = y;
      if (m == 3'd0 && o == 3'd7) srcx = b;
      nf[7] = y[7]; nf[6] = (y == 8'd0); nf[5] = srcx[5]; nf[3] = srcx[3];
      nf[4] = issub ? (h < 0) : (h > 15);
      nf[2] = (s > 127) || (s < -128);
      nf[1] = issub;
      nf[0] = (m == 3'd1 || m == 3'd2) ? f[0] : (issub ? (r < 0) : (r > 255));
      we = 1;
      if (m == 3'd0 && o >= 3'd4) begin
        y = (o == 3'd4) ? (a & b) : ((o == 3'd5) ? (a ^ b) : (a | b));
        nf = {y[7], y == 8'd0, y[5], o == 3'd4, y[3], ~^y, 1'b0, 1'b0};
        if (o == 3'd7) begin
          y = a;
          nf = {8'(r) >= 8'd128, 8'(r) == 8'd0, b[5], h < 0, b[3],
                (s > 127) || (s < -128), 1'b1, r < 0};
          we = 0;
        end
      end
    end else if (m == 3'd4) begin
      y = ~a; we = 1;
      nf = {f[7], f[6], y[5], 1'b1, y[3], f[2], 1'b1, f[0]};
    end else if (m == 3'd5) begin
      nf = {f[7], f[6], a[5], 1'b0, a[3], f[2], 1'b0, 1'b1};
    end else if (m == 3'd6) begin
      nf = {f[7], f[6], a[5], f[0], a[3], f[2], 1'b0, ~f[0]};
    end
    return {we, nf, y};
  endfunction

  task automatic apply(input logic [2:0] m, input logic [2:0] o, input logic [7:0] a,
      input logic [7:0] b, input logic [7:0] f, input string req);
    logic [16:0] exp, act;
    @(negedge clk);
    mode = m; op = o; acc = a; opnd = b; flags_in = f;
    @(posedge clk);
    #1;
    exp = model(m, o, a, b, f);
    act = {res_we, flags_out, res_out};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s mode=%0d op=%0d a=%h b=%h f=%h actual=%h expected=%h",
               req, m, o, a, b, f, act, exp);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1; mode = 3'd4; acc = 8'h5A; flags_in = 8'hFF;
    @(posedge clk); #1;
    checks++;
    if ({res_we, flags_out, res_out} !== 17'd0) begin
      errors++;
      $display("FAIL R2 actual=%h expected=0", {res_we, flags_out, res_out});
    end
    @(negedge clk); rst = 0;
  endtask

  task automatic t_adc_sweep;
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int c = 0; c < 2; c++)
          apply(3'd1 - 3'd1, 3'd1, 8'(a), 8'(b), {7'b0101010, 1'(c)}, "R1");
  endtask

  task automatic t_arith;
    for (int a = 0; a < 256; a += 7)
      for (int b = 0; b < 256; b += 11) begin
        apply(3'd0, 3'd0, 8'(a), 8'(b), 8'h00, "R1");
        apply(3'd0, 3'd2, 8'(a), 8'(b), 8'h00, "R1");
        apply(3'd0, 3'd3, 8'(a), 8'(b), 8'h01, "R1");
        apply(3'd0, 3'd3, 8'(a), 8'(b), 8'hFE, "R9");
      end
    apply(3'd0, 3'd2, 8'h80, 8'h01, 8'h00, "R1");
    apply(3'd0, 3'd0, 8'h7F, 8'h01, 8'h00, "R1");
  endtask

  task automatic t_logic;
    for (int a = 0; a < 256; a += 7)
      for (int b = 0; b < 256; b += 13)
        for (int o = 4; o < 7; o++)
          apply(3'd0, 3'(o), 8'(a), 8'(b), 8'hFF, "R3");
  endtask

  task automatic t_cmp;
    for (int a = 0; a < 256; a += 5)
      for (int b = 0; b < 256; b += 9)
        apply(3'd0, 3'd7, 8'(a), 8'(b), 8'(a ^ b), "R4");
    apply(3'd0, 3'd7, 8'h00, 8'h28, 8'h00, "R4");
    apply(3'd0, 3'd7, 8'h28, 8'h00, 8'h01, "R4");
  endtask

  task automatic t_incdec;
    for (int b = 0; b < 256; b++)
      for (int c = 0; c < 2; c++) begin
        apply(3'd1, 3'd0, 8'h33, 8'(b), {7'b1010101, 1'(c)}, "R5");
        apply(3'd2, 3'd0, 8'h33, 8'(b), {7'b0000000, 1'(c)}, "R5");
      end
  endtask

  task automatic t_neg;
    for (int a = 0; a < 256; a++)
      apply(3'd3, 3'd0, 8'(a), 8'h55, 8'hFF, "R7");
  endtask

  task automatic t_cpl;
    for (int a = 0; a < 256; a += 3)
      apply(3'd4, 3'd0, 8'(a), 8'h00, 8'(a * 7), "R6");
  endtask

  task automatic t_carry_ops;
    for (int a = 0; a < 256; a += 17)
      for (int f = 0; f < 256; f += 29) begin
        apply(3'd5, 3'd0, 8'(a), 8'h00, 8'(f), "R8");
        apply(3'd6, 3'd0, 8'(a), 8'h00, 8'(f), "R8");
        apply(3'd6, 3'd0, 8'(a), 8'h00, 8'(f) ^ 8'h01, "R8");
      end
  endtask

  task automatic t_idle;
    for (int f = 0; f < 256; f += 23)
      apply(3'd7, 3'(f), 8'(f + 1), 8'(f + 2), 8'(f), "R10");
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_adc_sweep();
    t_arith();
    t_logic();
    t_cmp();
    t_incdec();
    t_neg();
    t_cpl();
    t_carry_ops();
    t_idle();
    t_reset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule